// File: doc/BRIEF.md
# Masked Two-Stage Interrupt Controller

This block gathers a set of interrupt request lines and turns them into two processor requests: a normal request (irq_o) and a fast request (fiq_o). Each line is first latched into a raw pending register, which holds the event until software acknowledges it. Among the raw pending lines that are enabled and routed to the normal request, one winner is moved into a service register. A readable index register tells the handler which line won, so it does not have to scan.

Some main sources are shared by several secondary request lines. Each secondary line has its own enable bit. Enabled secondary lines are ORed into their shared main source before latching. A handler ends service by writing the winner's bit to the raw pending register and then to the service register. The next winner is chosen once the service register is empty.

Software reaches the block through a small word-addressed register port with single-cycle writes and registered reads.

Top module: `vic_mask_ctrl`

## Requirements
- R1: After reset the enable-mask register reads all ones, the route register reads zero, the secondary mask reads all ones in its N_SUB bits, both pending registers read zero, and irq_o and fiq_o are low.
- R2: A raw pending bit is set in the cycle after its effective request is high, whatever the mask. It stays set after the request drops. Only a write to word 3 with a 1 in that bit position clears it, and 0 bits in such a write change nothing.
- R3: A mask bit of 1 (word 1) keeps its source out of service selection and out of fiq_o, while the raw bit still latches. Clearing the mask bit later lets the held raw bit be served.
- R4: When the service register (word 4) is empty, the lowest-index raw pending source that is unmasked and in normal route is loaded as a single set bit. Its index is reported in word 5.
- R5: While the service register is non-zero, it keeps its bit even when lower-index sources become pending. Only a write of 1 to its set bit in word 4 empties it.
- R6: irq_o is high exactly while the service register is non-zero.
- R7: A route bit of 1 (word 0) sends its source to the fast path. fiq_o is high while any unmasked fast-route source is raw pending, and such a source never enters the service register.
- R8: Secondary line k feeds main source SUB_FIRST + k / SUB_PER_SRC (default: lines 2 and 3 feed source 29). A secondary line whose bit in word 2 is 1 has no effect.
- R9: Word map: 0 route, 1 mask, 2 secondary mask, 3 raw pending, 4 service, 5 index. Read data appears on rdata_o after the clock edge that samples rd_en_i.
- R10: The end-of-service sequence leaves the next winner among the remaining pending sources in service. After the last one it leaves both pending registers empty and irq_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | N_SRC | Main interrupt request lines, active high |
| sub_i | input | N_SUB | Secondary request lines, active high |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The checker treats a write to word 3 or word 4 as the only event that can lower a pending bit. It also assumes the service register is reloaded only while empty. Both hold as long as the bench changes the request lines and the register strobes only at falling edges. The bench never drives a read and a write in the same cycle. It waits at least three edges after each request pulse before sampling, so every raw, service and output register has settled.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;
  localparam logic [ADDR_W-1:0] A_ROUTE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd1;
  localparam logic [ADDR_W-1:0] A_SUBMSK = 3'd2;
  localparam logic [ADDR_W-1:0] A_RAW    = 3'd3;
  localparam logic [ADDR_W-1:0] A_SVC    = 3'd4;
  localparam logic [ADDR_W-1:0] A_INDEX  = 3'd5;
endpackage

// File: rtl/vic_req_merge.sv
module vic_req_merge #(
  parameter int N_SRC       = 32,
  parameter int N_SUB       = 6,
  parameter int SUB_PER_SRC = 2,
  parameter int SUB_FIRST   = 28
) (
  input  logic [N_SRC-1:0] src_i,
  input  logic [N_SUB-1:0] sub_i,
  input  logic [N_SUB-1:0] sub_mask_i,
  output logic [N_SRC-1:0] req_o
);
  localparam int N_GRP = N_SUB / SUB_PER_SRC;

  logic [N_GRP-1:0] grp_hit;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_hit[g] = |(sub_i[g*SUB_PER_SRC +: SUB_PER_SRC] &
                          ~sub_mask_i[g*SUB_PER_SRC +: SUB_PER_SRC]);
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (i >= SUB_FIRST && i < SUB_FIRST + N_GRP) begin : g_shared
      assign req_o[i] = src_i[i] | grp_hit[i-SUB_FIRST];
    end else begin : g_plain
      assign req_o[i] = src_i[i];
    end
  end
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int N     = 32,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     cand_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     onehot_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
    onehot_o = hit_o ? (N'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/vic_mask_ctrl.sv
module vic_mask_ctrl
  import vic_pkg::*;
#(
  parameter int N_SRC       = 32,
  parameter int N_SUB       = 6,
  parameter int SUB_PER_SRC = 2,
  parameter int SUB_FIRST   = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [N_SUB-1:0]  sub_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] route_q, mask_q, raw_q, svc_q;
  logic [N_SUB-1:0] submask_q;
  logic [IDX_W-1:0] idx_q;
  logic [N_SRC-1:0] req, raw_nxt, svc_nxt, cand, pick_oh;
  logic [IDX_W-1:0] pick_idx, idx_nxt;
  logic             pick_hit;
  logic             wr_raw, wr_svc;
  logic [DATA_W-1:0] rd_mux;

  vic_req_merge #(
    .N_SRC(N_SRC), .N_SUB(N_SUB), .SUB_PER_SRC(SUB_PER_SRC), .SUB_FIRST(SUB_FIRST)
  ) u_merge (
    .src_i(src_i), .sub_i(sub_i), .sub_mask_i(submask_q), .req_o(req)
  );

  assign cand = raw_q & ~mask_q & ~route_q;

  vic_prio_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick (
    .cand_i(cand), .hit_o(pick_hit), .idx_o(pick_idx), .onehot_o(pick_oh)
  );

  assign wr_raw = wr_en_i && (addr_i == A_RAW);
  assign wr_svc = wr_en_i && (addr_i == A_SVC);

  always_comb begin
    raw_nxt = (raw_q & ~(wr_raw ? wdata_i[N_SRC-1:0] : '0)) | req;
    svc_nxt = svc_q;
    idx_nxt = idx_q;
    if (svc_q == '0) begin
      if (pick_hit) begin
        svc_nxt = pick_oh;
        idx_nxt = pick_idx;
      end
    end else if (wr_svc) begin
      svc_nxt = svc_q & ~wdata_i[N_SRC-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_ROUTE:  rd_mux[N_SRC-1:0] = route_q;
      A_MASK:   rd_mux[N_SRC-1:0] = mask_q;
      A_SUBMSK: rd_mux[N_SUB-1:0] = submask_q;
      A_RAW:    rd_mux[N_SRC-1:0] = raw_q;
      A_SVC:    rd_mux[N_SRC-1:0] = svc_q;
      A_INDEX:  rd_mux[IDX_W-1:0] = idx_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q   <= '0;
      mask_q    <= '1;
      submask_q <= '1;
      raw_q     <= '0;
      svc_q     <= '0;
      idx_q     <= '0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
      rdata_o   <= '0;
    end else begin
      if (wr_en_i && addr_i == A_ROUTE)  route_q   <= wdata_i[N_SRC-1:0];
      if (wr_en_i && addr_i == A_MASK)   mask_q    <= wdata_i[N_SRC-1:0];
      if (wr_en_i && addr_i == A_SUBMSK) submask_q <= wdata_i[N_SUB-1:0];
      raw_q <= raw_nxt;
      svc_q <= svc_nxt;
      idx_q <= idx_nxt;
      irq_o <= |svc_nxt;
      fiq_o <= |(raw_q & ~mask_q & route_q);
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/vic_mask_ctrl_chk.sv
module vic_mask_ctrl_chk
  import vic_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [N_SRC-1:0]  raw_q,
  input logic [N_SRC-1:0]  svc_q,
  input logic [N_SRC-1:0]  mask_q,
  input logic [N_SRC-1:0]  route_q,
  input logic              irq_o
);
  a_r4_svc_single: assert property (@(posedge clk) disable iff (rst)
    $onehot0(svc_q));

  a_r6_irq_follows_svc: assert property (@(posedge clk) disable iff (rst)
    irq_o == (svc_q != '0));

  a_r5_svc_held: assert property (@(posedge clk) disable iff (rst)
    ((svc_q != '0) && !(wr_en_i && addr_i == A_SVC)) |=> $stable(svc_q));

  a_r4_load_legal: assert property (@(posedge clk) disable iff (rst)
    (svc_q == '0) |=>
      ((svc_q & $past(raw_q) & ~$past(mask_q) & ~$past(route_q)) == svc_q));

  a_r2_raw_sticky: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_i && addr_i == A_RAW) |=> ((~raw_q & $past(raw_q)) == '0));
endmodule

bind vic_mask_ctrl vic_mask_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .raw_q(raw_q), .svc_q(svc_q), .mask_q(mask_q), .route_q(route_q),
  .irq_o(irq_o)
);

// File: tb/sim_vic_mask_ctrl.sv
module sim_vic_mask_ctrl;
  localparam int N_SRC = 32;
  localparam int N_SUB = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N_SRC-1:0] src_i = '0;
  logic [N_SUB-1:0] sub_i = '0;
  logic             wr_en_i = 1'b0;
  logic             rd_en_i = 1'b0;
  logic [2:0]       addr_i = '0;
  logic [31:0]      wdata_i = '0;
  logic [31:0]      rdata_o;
  logic             irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vic_mask_ctrl u0 (
    .clk(clk), .rst(rst), .src_i(src_i), .sub_i(sub_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    tick();
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    rd_en_i = 1'b1; addr_i = a;
    tick();
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    bus_read(a, v);
    check(v == exp, req, v, exp);
  endtask

  task automatic pulse_src(input logic [31:0] bits);
    src_i = bits;
    tick();
    src_i = '0;
    tick(); tick();
  endtask

  task automatic t_reset();
    check(irq_o == 1'b0, "R1 irq", 32'(irq_o), 0);
    check(fiq_o == 1'b0, "R1 fiq", 32'(fiq_o), 0);
    expect_reg(3'd1, 32'hFFFF_FFFF, "R1 mask");
    expect_reg(3'd0, 32'h0, "R1 route");
    expect_reg(3'd2, 32'h3F, "R1 submask");
    expect_reg(3'd3, 32'h0, "R1 raw");
    expect_reg(3'd4, 32'h0, "R1 svc");
  endtask

  task automatic t_sticky_masked();
    pulse_src(32'h20);
    expect_reg(3'd3, 32'h20, "R2 raw latched");
    check(irq_o == 1'b0, "R3 masked no irq", 32'(irq_o), 0);
    expect_reg(3'd4, 32'h0, "R3 masked no svc");
    bus_write(3'd3, 32'hFFFF_FFDF);
    expect_reg(3'd3, 32'h20, "R2 zero bits keep");
    bus_write(3'd1, 32'hFFFF_FFDF);
    tick(); tick();
    expect_reg(3'd4, 32'h20, "R3 unmask serves");
    expect_reg(3'd5, 32'd5, "R4 index 5");
    bus_write(3'd3, 32'h20);
    bus_write(3'd4, 32'h20);
    tick(); tick();
    expect_reg(3'd3, 32'h0, "R2 raw cleared");
    check(irq_o == 1'b0, "R10 irq low", 32'(irq_o), 0);
    bus_write(3'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_select();
    bus_write(3'd1, ~32'h20A);
    pulse_src(32'h208);
    expect_reg(3'd4, 32'h8, "R4 lowest wins");
    expect_reg(3'd5, 32'd3, "R4 index 3");
    check(irq_o == 1'b1, "R6 irq high", 32'(irq_o), 1);
    pulse_src(32'h2);
    expect_reg(3'd4, 32'h8, "R5 no preempt");
    expect_reg(3'd3, 32'h20A, "R2 raw holds all");
    bus_write(3'd3, 32'h8);
    tick(); tick();
    expect_reg(3'd4, 32'h8, "R5 raw clear keeps svc");
    bus_write(3'd4, 32'h8);
    tick(); tick();
    expect_reg(3'd4, 32'h2, "R10 next winner");
    expect_reg(3'd5, 32'd1, "R10 index 1");
    bus_write(3'd3, 32'h2);
    bus_write(3'd4, 32'h2);
    tick(); tick();
    expect_reg(3'd5, 32'd9, "R10 index 9");
    bus_write(3'd3, 32'h200);
    bus_write(3'd4, 32'h200);
    tick(); tick();
    expect_reg(3'd4, 32'h0, "R10 svc empty");
    expect_reg(3'd3, 32'h0, "R10 raw empty");
    check(irq_o == 1'b0, "R6 irq low", 32'(irq_o), 0);
    bus_write(3'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_fast();
    bus_write(3'd0, 32'h80);
    bus_write(3'd1, ~32'h80);
    pulse_src(32'h80);
    check(fiq_o == 1'b1, "R7 fiq high", 32'(fiq_o), 1);
    check(irq_o == 1'b0, "R7 no irq", 32'(irq_o), 0);
    expect_reg(3'd4, 32'h0, "R7 not in svc");
    bus_write(3'd1, 32'hFFFF_FFFF);
    tick(); tick();
    check(fiq_o == 1'b0, "R3 mask drops fiq", 32'(fiq_o), 0);
    bus_write(3'd3, 32'h80);
    bus_write(3'd0, 32'h0);
    tick();
    expect_reg(3'd0, 32'h0, "R9 route readback");
  endtask

  task automatic t_sub();
    sub_i = 6'b001000;
    tick(); sub_i = '0; tick(); tick();
    expect_reg(3'd3, 32'h0, "R8 masked sub ignored");
    bus_write(3'd2, 32'h37);
    expect_reg(3'd2, 32'h37, "R9 submask readback");
    sub_i = 6'b001000;
    tick(); sub_i = '0; tick(); tick();
    expect_reg(3'd3, 32'h2000_0000, "R8 sub 3 to src 29");
    bus_write(3'd3, 32'h2000_0000);
    bus_write(3'd2, 32'h3F);
    tick();
    expect_reg(3'd3, 32'h0, "R2 cleared sub");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset();
    t_sticky_masked();
    t_select();
    t_fast();
    t_sub();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule